// File: doc/BRIEF.md
# Multi-input exclusive and parity gate

A combinational gate that takes a parameterized number of input buses, each a parameterized number of bits wide. It produces one bus of the same width. Every bit position is resolved on its own from the bits at that position across all input buses. A two-bit mode input chooses one of four functions:

- exactly-one exclusive OR;
- its complement;
- odd parity;
- even parity.

Each signal bit carries one of four states, held as a {valid, value} pair so the design stays synthesizable: floating, logic 0, logic 1, or error. A floating input bit takes no part in the function at its position, as if that input were absent. An all-floating position yields a floating output. Any error at a position forces an error at the output, and this rule takes priority over the floating rule. Bit j of input lane k sits at index k*WIDTH+j of the packed input vectors.

Top module: `xpg_gate`

## Requirements
- R1: With mode_i = 2'b00 (XOR), an output bit whose position has at least one non-floating input and no error is logic 1 when exactly one participating input is 1, and logic 0 otherwise.
- R2: With mode_i = 2'b01 (XNOR), an output bit is logic 1 whenever the number of participating 1 inputs differs from one, including zero, and logic 0 when it is exactly one.
- R3: With mode_i = 2'b10 (odd parity), an output bit is logic 1 when an odd number of participating inputs are 1, and logic 0 otherwise.
- R4: With mode_i = 2'b11 (even parity), an output bit is logic 1 when an even number of participating inputs are 1, and logic 0 otherwise.
- R5: A floating input bit does not change the output at its position. The result equals that of the same function over the remaining inputs only.
- R6: When every input bit at a position is floating, the output bit at that position is floating.
- R7: When any input bit at a position is an error, the output bit at that position is an error, even if all other inputs there are floating.
- R8: Bit positions are independent. The states at one position never change the output at another position.
- R9: Signal encoding is {valid, value}: 2'b00 floating, 2'b10 logic 0, 2'b11 logic 1, 2'b01 error. The output is an error only if some input at that position is an error.
- R10: With exactly two participating inputs, XOR equals odd parity and XNOR equals even parity. With three participating 1 inputs, XOR gives 0 and odd parity gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid_i | input | N_INPUTS*WIDTH | Valid half of each input bit, lane k bit j at k*WIDTH+j |
| in_value_i | input | N_INPUTS*WIDTH | Value half of each input bit, same layout |
| mode_i | input | 2 | Function select: 00 XOR, 01 XNOR, 10 odd parity, 11 even parity |
| out_valid_o | output | WIDTH | Valid half of each output bit |
| out_value_o | output | WIDTH | Value half of each output bit |

## Verification
The assertions assume that the inputs are settled when they are evaluated. They also assume that mode_i holds one of the four defined codes, which any two-bit value does. The error and floating checks assume the {valid, value} encoding of R9 and nothing else. The stimulus changes inputs only between clock edges and checks the outputs a fixed settle time later. It uses directed patterns for each mode and state rule, plus a seeded sweep over all four states at every lane and position.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
  typedef enum logic [1:0] {
    MODE_XOR  = 2'b00,
    MODE_XNOR = 2'b01,
    MODE_ODD  = 2'b10,
    MODE_EVEN = 2'b11
  } xpg_mode_e;

  // {valid, value}
  localparam logic [1:0] SIG_FLOAT = 2'b00;
  localparam logic [1:0] SIG_ERR   = 2'b01;
  localparam logic [1:0] SIG_ZERO  = 2'b10;
  localparam logic [1:0] SIG_ONE   = 2'b11;
endpackage

// File: rtl/xpg_tally.sv
module xpg_tally #(
  parameter int N_INPUTS = 4
) (
  input  logic [N_INPUTS-1:0] valid_i,
  input  logic [N_INPUTS-1:0] value_i,
  output logic                any_err_o,
  output logic                any_part_o,
  output logic                exactly_one_o,
  output logic                parity_o
);
  // saturating count of participating ones: 0, 1, 2+
  logic [1:0] ones_sat;

  always_comb begin
    any_err_o  = 1'b0;
    any_part_o = 1'b0;
    parity_o   = 1'b0;
    ones_sat   = 2'd0;
    for (int j = 0; j < N_INPUTS; j++) begin
      if (!valid_i[j] && value_i[j]) any_err_o = 1'b1;
      if (valid_i[j]) any_part_o = 1'b1;
      if (valid_i[j] && value_i[j]) begin
        parity_o = ~parity_o;
        if (ones_sat != 2'd2) ones_sat = ones_sat + 2'd1;
      end
    end
    exactly_one_o = (ones_sat == 2'd1);
  end
endmodule

// File: rtl/xpg_resolve.sv
module xpg_resolve
  import xpg_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       any_err_i,
  input  logic       any_part_i,
  input  logic       exactly_one_i,
  input  logic       parity_i,
  output logic       valid_o,
  output logic       value_o
);
  always_comb begin
    if (any_err_i) begin
      {valid_o, value_o} = SIG_ERR;
    end else if (!any_part_i) begin
      {valid_o, value_o} = SIG_FLOAT;
    end else begin
      valid_o = 1'b1;
      unique case (xpg_mode_e'(mode_i))
        MODE_XOR:  value_o = exactly_one_i;
        MODE_XNOR: value_o = ~exactly_one_i;
        MODE_ODD:  value_o = parity_i;
        MODE_EVEN: value_o = ~parity_i;
        default:   value_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (exactly_one_i) AST_ONE_IMPLIES_ODD: assert (parity_i); // R10
  end
endmodule

// File: rtl/xpg_gate.sv
module xpg_gate
  import xpg_pkg::*;
#(
  parameter int N_INPUTS = 4,
  parameter int WIDTH    = 3
) (
  input  logic [N_INPUTS*WIDTH-1:0] in_valid_i,
  input  logic [N_INPUTS*WIDTH-1:0] in_value_i,
  input  logic [1:0]                mode_i,
  output logic [WIDTH-1:0]          out_valid_o,
  output logic [WIDTH-1:0]          out_value_o
);
  localparam int TOTAL = N_INPUTS * WIDTH;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [N_INPUTS-1:0] lane_valid;
    logic [N_INPUTS-1:0] lane_value;
    logic                any_err;
    logic                any_part;
    logic                exactly_one;
    logic                parity;

    for (genvar k = 0; k < N_INPUTS; k++) begin : g_lane
      assign lane_valid[k] = in_valid_i[k*WIDTH+b];
      assign lane_value[k] = in_value_i[k*WIDTH+b];
    end

    xpg_tally #(.N_INPUTS(N_INPUTS)) u_tally (
      .valid_i       (lane_valid),
      .value_i       (lane_value),
      .any_err_o     (any_err),
      .any_part_o    (any_part),
      .exactly_one_o (exactly_one),
      .parity_o      (parity)
    );

    xpg_resolve u_resolve (
      .mode_i        (mode_i),
      .any_err_i     (any_err),
      .any_part_i    (any_part),
      .exactly_one_i (exactly_one),
      .parity_i      (parity),
      .valid_o       (out_valid_o[b]),
      .value_o       (out_value_o[b])
    );
  end

  // port-level checks on each position
  always_comb begin
    for (int b = 0; b < WIDTH; b++) begin
      logic err_seen;
      logic all_float;
      err_seen  = 1'b0;
      all_float = 1'b1;
      for (int k = 0; k < N_INPUTS; k++) begin
        if ({in_valid_i[k*WIDTH+b], in_value_i[k*WIDTH+b]} == SIG_ERR) err_seen = 1'b1;
        if ({in_valid_i[k*WIDTH+b], in_value_i[k*WIDTH+b]} != SIG_FLOAT) all_float = 1'b0;
      end
      if (err_seen) AST_ERR_WINS: assert ({out_valid_o[b], out_value_o[b]} == SIG_ERR); // R7
      if (all_float) AST_ALL_FLOAT: assert ({out_valid_o[b], out_value_o[b]} == SIG_FLOAT); // R6
      if (!err_seen) AST_NO_SPURIOUS_ERR: assert ({out_valid_o[b], out_value_o[b]} != SIG_ERR); // R9
    end
  end

  initial AST_SIZE_OK: assert (TOTAL == N_INPUTS * WIDTH && N_INPUTS >= 1); // R8
endmodule

// File: tb/xpg_gate_bench.sv
module xpg_gate_bench;
  localparam int N = 4;
  localparam int W = 3;
  localparam logic [1:0] FL = 2'b00, ER = 2'b01, Z0 = 2'b10, O1 = 2'b11;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N*W-1:0] vld = '0;
  logic [N*W-1:0] val = '0;
  logic [1:0]     mode = 2'b00;
  logic [W-1:0]   out_valid, out_value;
  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  xpg_gate #(.N_INPUTS(N), .WIDTH(W)) u_xpg_gate (
    .in_valid_i (vld),
    .in_value_i (val),
    .mode_i     (mode),
    .out_valid_o(out_valid),
    .out_value_o(out_value)
  );

  function automatic logic [1:0] model(input logic [1:0] m, input logic [N*W-1:0] v,
                                       input logic [N*W-1:0] d, input int b);
    int ones = 0;
    bit err = 0, part = 0;
    for (int k = 0; k < N; k++) begin
      logic [1:0] c;
      c = {v[k*W+b], d[k*W+b]};
      if (c == ER) err = 1;
      if (c == Z0 || c == O1) part = 1;
      if (c == O1) ones++;
    end
    if (err) return ER;
    if (!part) return FL;
    case (m)
      2'b00:   return (ones == 1) ? O1 : Z0;
      2'b01:   return (ones != 1) ? O1 : Z0;
      2'b10:   return (ones % 2 == 1) ? O1 : Z0;
      default: return (ones % 2 == 0) ? O1 : Z0;
    endcase
  endfunction

  task automatic set_lane(input int k, input int b, input logic [1:0] c);
    vld[k*W+b] = c[1];
    val[k*W+b] = c[0];
  endtask

  task automatic set_all(input logic [1:0] c);
    for (int k = 0; k < N; k++)
      for (int b = 0; b < W; b++) set_lane(k, b, c);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check_bit(input int b, input logic [1:0] exp, input string tag);
    tests++;
    if ({out_valid[b], out_value[b]} !== exp) begin
      fails++;
      $display("FAIL %s bit %0d: got %b expected %b", tag, b, {out_valid[b], out_value[b]}, exp);
    end
  endtask

  task automatic check_model(input string tag);
    for (int b = 0; b < W; b++) check_bit(b, model(mode, vld, val, b), tag);
  endtask

  task automatic t_reset_state();
    set_all(FL);
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      settle();
      for (int b = 0; b < W; b++) check_bit(b, FL, "R6 all floating");
    end
  endtask

  task automatic t_xor();
    set_all(Z0);
    mode = 2'b00;
    set_lane(0, 0, O1);
    set_lane(0, 1, O1); set_lane(1, 1, O1); set_lane(2, 1, O1);
    settle();
    check_bit(0, O1, "R1 xor single one");
    check_bit(1, Z0, "R1 xor three ones");
    check_bit(2, Z0, "R1 xor no ones");
  endtask

  task automatic t_xnor();
    set_all(Z0);
    mode = 2'b01;
    set_lane(3, 0, O1);
    set_lane(0, 1, O1); set_lane(1, 1, O1);
    settle();
    check_bit(0, Z0, "R2 xnor single one");
    check_bit(1, O1, "R2 xnor two ones");
    check_bit(2, O1, "R2 xnor zero ones");
  endtask

  task automatic t_odd_even();
    set_all(Z0);
    set_lane(0, 0, O1); set_lane(1, 0, O1); set_lane(2, 0, O1);
    set_lane(0, 1, O1); set_lane(3, 1, O1);
    mode = 2'b10;
    settle();
    check_bit(0, O1, "R3 odd three ones");
    check_bit(1, Z0, "R3 odd two ones");
    check_bit(2, Z0, "R3 odd zero ones");
    mode = 2'b11;
    settle();
    check_bit(0, Z0, "R4 even three ones");
    check_bit(1, O1, "R4 even two ones");
    check_bit(2, O1, "R4 even zero ones");
  endtask

  task automatic t_float_ignored();
    set_all(FL);
    set_lane(2, 0, O1);
    set_lane(1, 1, Z0);
    set_lane(0, 2, O1); set_lane(3, 2, O1);
    mode = 2'b00;
    settle();
    check_bit(0, O1, "R5 xor lone one among floats");
    check_bit(1, Z0, "R5 xor lone zero among floats");
    check_bit(2, Z0, "R5 xor two ones among floats");
    mode = 2'b11;
    settle();
    check_bit(1, O1, "R5 even lone zero among floats");
  endtask

  task automatic t_error();
    set_all(FL);
    set_lane(1, 0, ER);
    set_all(O1);
    set_lane(1, 0, ER);
    for (int k = 0; k < N; k++) set_lane(k, 1, FL);
    set_lane(3, 1, ER);
    mode = 2'b10;
    settle();
    check_bit(0, ER, "R7 error among ones");
    check_bit(1, ER, "R7 error among floats");
    check_bit(2, Z0, "R9 clean bit has no error");
  endtask

  task automatic t_bitwise();
    set_all(Z0);
    set_lane(0, 0, ER);
    set_lane(0, 2, O1);
    for (int k = 0; k < N; k++) set_lane(k, 1, FL);
    mode = 2'b00;
    settle();
    check_bit(0, ER, "R8 bit0 error");
    check_bit(1, FL, "R8 bit1 floating");
    check_bit(2, O1, "R8 bit2 unaffected by neighbours");
  endtask

  task automatic t_two_input();
    for (int p = 0; p < 4; p++) begin
      set_all(FL);
      for (int b = 0; b < W; b++) begin
        set_lane(0, b, p[0] ? O1 : Z0);
        set_lane(2, b, p[1] ? O1 : Z0);
      end
      mode = 2'b00; settle();
      check_bit(0, (p[0] ^ p[1]) ? O1 : Z0, "R10 two-input xor");
      mode = 2'b10; settle();
      check_bit(0, (p[0] ^ p[1]) ? O1 : Z0, "R10 two-input odd");
      mode = 2'b01; settle();
      check_bit(0, (p[0] ^ p[1]) ? Z0 : O1, "R10 two-input xnor");
      mode = 2'b11; settle();
      check_bit(0, (p[0] ^ p[1]) ? Z0 : O1, "R10 two-input even");
    end
  endtask

  task automatic t_sweep();
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < N; k++)
        for (int b = 0; b < W; b++) begin
          int r;
          r = $urandom_range(0, 9);
          set_lane(k, b, (r < 4) ? O1 : (r < 7) ? Z0 : (r < 9) ? FL : ER);
        end
      mode = i[1:0];
      settle();
      check_model("R1 R2 R3 R4 R5 sweep");
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_xor();
    t_xnor();
    t_odd_even();
    t_float_ignored();
    t_error();
    t_bitwise();
    t_two_input();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule